// File: doc/BRIEF.md
# Supply and Output Supervisor

This block watches two digitized voltages of a boost power-factor stage, the controller supply rail and the scaled output-feedback node, and turns them into the control flags the stage needs. Each comparison is a threshold pair with hysteresis. The block produces a run-enable for undervoltage lockout, an over-voltage shutdown flag, a feedback-low disable flag, a combined gate-permit and a pull-low request for an open-drain "output ready" pin. The gate driver uses the gate-permit, and a pad cell with an external pull-up turns the ready request into the pin level.

Samples arrive as unsigned millivolt codes with a valid strobe. All state changes only on cycles that carry a valid sample. The ready pin is sequenced by a four-state machine:
- RS_FLOAT: the pin is released because the supply is too low to drive it.
- RS_HOLD_LOW: the pin is pulled low and not yet armed.
- RS_ARMED_LOW: the pin is armed and pulled low.
- RS_ARMED_HIGH: the pin is armed and released, so it reads high.

The machine has these transitions:
- FLOAT_ENTER: the supply falls below the float level, from any state.
- COLLAPSE: the supply is at or above the float level but below the collapse level, from any state. The next state is RS_HOLD_LOW.
- ARM: the state is RS_FLOAT or RS_HOLD_LOW and the supply exceeds the start level. The next state is RS_ARMED_HIGH or RS_ARMED_LOW, depending on the feedback.
- WAIT: the state is RS_FLOAT or RS_HOLD_LOW and the supply does not exceed the start level. The next state is RS_HOLD_LOW.
- RISE: the state is RS_ARMED_LOW and the feedback exceeds the ready-on level. The next state is RS_ARMED_HIGH.
- DROP: the state is RS_ARMED_HIGH and the feedback falls below the ready-off level. The next state is RS_ARMED_LOW.

Top module: `supply_supervisor`

## Requirements
- R1: On a valid sample, run_en sets when sup_mv > 12000 and clears when sup_mv < 8500. Values between the two levels, or equal to either one, leave run_en unchanged.
- R2: On a valid sample, ovp_trip sets when fb_mv > 2675 and clears when fb_mv < 2500. Values in between leave it unchanged.
- R3: On a valid sample, fb_disabled sets when fb_mv < 350 and clears when fb_mv > 450. Values in between leave it unchanged.
- R4: gate_permit is 1 exactly when run_en is 1, ovp_trip is 0 and fb_disabled is 0.
- R5: While armed, the ready pin is released (rdy_pull_low = 0) after a sample with fb_mv > 2240. It is pulled low after a sample with fb_mv < 2051. Samples in between keep it as it was.
- R6: The ready pin is not armed until a sample has sup_mv > 12000. While unarmed and sup_mv >= 2000, rdy_pull_low is 1 whatever the feedback is. At the arming sample the pin is released only if fb_mv > 2240.
- R7: Once armed, the ready pin stays armed and keeps following R5 when sup_mv falls below 8500 and run_en drops. Only a sample below 5000 ends the armed state.
- R8: A valid sample with 2000 <= sup_mv < 5000 forces rdy_pull_low to 1 and disarms.
- R9: A valid sample with sup_mv < 2000 releases the pin (rdy_pull_low = 0) and disarms.
- R10: Without smp_vld no flag or ready state changes. Each valid sample takes effect on the clock edge that captures it.
- R11: Synchronous active-high rst clears run_en, ovp_trip, fb_disabled and gate_permit, and releases the ready pin (rdy_pull_low = 0, state RS_FLOAT).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe; the inputs are used only when it is high |
| sup_mv | input | SUP_W (15) | Supply rail sample in millivolts |
| fb_mv | input | FB_W (12) | Scaled output-feedback sample in millivolts |
| run_en | output | 1 | Undervoltage-lockout run enable |
| ovp_trip | output | 1 | Over-voltage shutdown flag |
| fb_disabled | output | 1 | Feedback-low disable flag |
| gate_permit | output | 1 | Gate switching allowed |
| rdy_pull_low | output | 1 | Request to pull the open-drain ready pin low |

## Verification
Every flag and the ready state are registered once behind the sample. A valid sample presented before a rising edge is visible on all five outputs immediately after that edge, and gate_permit follows in the same cycle because it is combinational from the flags. The bench drives each sample on a falling edge, updates its reference model for the coming rising edge, and compares all outputs at the following falling edge. Cycles without a valid strobe use the same one-cycle schedule and must show the previous values.

// File: rtl/sos_pkg.sv
package sos_pkg;

    // Ready-pin sequencing states
    typedef enum logic [1:0] {
        RS_FLOAT      = 2'd0,
        RS_HOLD_LOW   = 2'd1,
        RS_ARMED_LOW  = 2'd2,
        RS_ARMED_HIGH = 2'd3
    } rdy_state_t;

    function automatic logic rdy_pulls(input rdy_state_t s);
        return (s == RS_HOLD_LOW) || (s == RS_ARMED_LOW);
    endfunction

endpackage

// File: rtl/sos_hyst_cmp.sv
module sos_hyst_cmp #(
    parameter int W         = 12,
    parameter int SET_LVL   = 0,
    parameter int CLR_LVL   = 0,
    parameter bit RISE_SETS = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         smp_vld,
    input  logic [W-1:0] smp,
    output logic         flag
);
    localparam logic [W-1:0] SET_C = W'(SET_LVL);
    localparam logic [W-1:0] CLR_C = W'(CLR_LVL);

    logic set_hit;
    logic clr_hit;

    generate
        if (RISE_SETS) begin : g_rise
            assign set_hit = smp > SET_C;
            assign clr_hit = smp < CLR_C;
        end else begin : g_fall
            assign set_hit = smp < SET_C;
            assign clr_hit = smp > CLR_C;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (smp_vld) begin
            if (set_hit) begin
                flag <= 1'b1;
            end else if (clr_hit) begin
                flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sos_rdy_fsm.sv
module sos_rdy_fsm
    import sos_pkg::*;
#(
    parameter int SUP_W       = 15,
    parameter int FB_W        = 12,
    parameter int START_MV    = 12000,
    parameter int COLLAPSE_MV = 5000,
    parameter int FLOAT_MV    = 2000,
    parameter int RDY_ON_MV   = 2240,
    parameter int RDY_OFF_MV  = 2051
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_vld,
    input  logic [SUP_W-1:0] sup,
    input  logic [FB_W-1:0]  fb,
    output logic             pull_low
);
    localparam logic [SUP_W-1:0] START_C    = SUP_W'(START_MV);
    localparam logic [SUP_W-1:0] COLLAPSE_C = SUP_W'(COLLAPSE_MV);
    localparam logic [SUP_W-1:0] FLOAT_C    = SUP_W'(FLOAT_MV);
    localparam logic [FB_W-1:0]  ON_C       = FB_W'(RDY_ON_MV);
    localparam logic [FB_W-1:0]  OFF_C      = FB_W'(RDY_OFF_MV);

    rdy_state_t cur;
    rdy_state_t nxt;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= RS_FLOAT;
        end else begin
            cur <= nxt;
        end
    end

    // Transitions
    always_comb begin
        nxt = cur;
        if (smp_vld) begin
            if (sup < FLOAT_C) begin
                nxt = RS_FLOAT;                      // FLOAT_ENTER
            end else if (sup < COLLAPSE_C) begin
                nxt = RS_HOLD_LOW;                   // COLLAPSE
            end else begin
                unique case (cur)
                    RS_FLOAT, RS_HOLD_LOW: begin
                        if (sup > START_C) begin     // ARM
                            nxt = (fb > ON_C) ? RS_ARMED_HIGH : RS_ARMED_LOW;
                        end else begin               // WAIT
                            nxt = RS_HOLD_LOW;
                        end
                    end
                    RS_ARMED_LOW: begin
                        if (fb > ON_C) begin
                            nxt = RS_ARMED_HIGH;     // RISE
                        end
                    end
                    RS_ARMED_HIGH: begin
                        if (fb < OFF_C) begin
                            nxt = RS_ARMED_LOW;      // DROP
                        end
                    end
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        pull_low = rdy_pulls(cur);
    end
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor #(
    parameter int SUP_W       = 15,
    parameter int FB_W        = 12,
    parameter int START_MV    = 12000,
    parameter int STOP_MV     = 8500,
    parameter int OVP_ON_MV   = 2675,
    parameter int OVP_OFF_MV  = 2500,
    parameter int DIS_ON_MV   = 350,
    parameter int DIS_OFF_MV  = 450,
    parameter int RDY_ON_MV   = 2240,
    parameter int RDY_OFF_MV  = 2051,
    parameter int COLLAPSE_MV = 5000,
    parameter int FLOAT_MV    = 2000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_vld,
    input  logic [SUP_W-1:0] sup_mv,
    input  logic [FB_W-1:0]  fb_mv,
    output logic             run_en,
    output logic             ovp_trip,
    output logic             fb_disabled,
    output logic             gate_permit,
    output logic             rdy_pull_low
);
    sos_hyst_cmp #(
        .W(SUP_W), .SET_LVL(START_MV), .CLR_LVL(STOP_MV), .RISE_SETS(1'b1)
    ) u_uvlo (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp(sup_mv), .flag(run_en)
    );

    sos_hyst_cmp #(
        .W(FB_W), .SET_LVL(OVP_ON_MV), .CLR_LVL(OVP_OFF_MV), .RISE_SETS(1'b1)
    ) u_ovp (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp(fb_mv), .flag(ovp_trip)
    );

    sos_hyst_cmp #(
        .W(FB_W), .SET_LVL(DIS_ON_MV), .CLR_LVL(DIS_OFF_MV), .RISE_SETS(1'b0)
    ) u_dis (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp(fb_mv), .flag(fb_disabled)
    );

    sos_rdy_fsm #(
        .SUP_W(SUP_W), .FB_W(FB_W), .START_MV(START_MV),
        .COLLAPSE_MV(COLLAPSE_MV), .FLOAT_MV(FLOAT_MV),
        .RDY_ON_MV(RDY_ON_MV), .RDY_OFF_MV(RDY_OFF_MV)
    ) u_rdy (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .sup(sup_mv), .fb(fb_mv),
        .pull_low(rdy_pull_low)
    );

    always_comb begin
        gate_permit = run_en & ~ovp_trip & ~fb_disabled;
    end
endmodule

// File: rtl/supply_supervisor_chk.sv
module supply_supervisor_chk #(
    parameter int SUP_W       = 15,
    parameter int FB_W        = 12,
    parameter int START_MV    = 12000,
    parameter int STOP_MV     = 8500,
    parameter int OVP_ON_MV   = 2675,
    parameter int DIS_ON_MV   = 350,
    parameter int COLLAPSE_MV = 5000,
    parameter int FLOAT_MV    = 2000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_vld,
    input  logic [SUP_W-1:0] sup_mv,
    input  logic [FB_W-1:0]  fb_mv,
    input  logic             run_en,
    input  logic             ovp_trip,
    input  logic             fb_disabled,
    input  logic             gate_permit,
    input  logic             rdy_pull_low
);
    localparam logic [SUP_W-1:0] START_C    = SUP_W'(START_MV);
    localparam logic [SUP_W-1:0] STOP_C     = SUP_W'(STOP_MV);
    localparam logic [SUP_W-1:0] COLLAPSE_C = SUP_W'(COLLAPSE_MV);
    localparam logic [SUP_W-1:0] FLOAT_C    = SUP_W'(FLOAT_MV);
    localparam logic [FB_W-1:0]  OVP_C      = FB_W'(OVP_ON_MV);
    localparam logic [FB_W-1:0]  DIS_C      = FB_W'(DIS_ON_MV);

    AST_RUN_STARTS: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && sup_mv > START_C) |=> run_en); // R1
    AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (run_en && smp_vld && sup_mv >= STOP_C) |=> run_en); // R1
    AST_OVP_TRIPS: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && fb_mv > OVP_C) |=> (ovp_trip && !gate_permit)); // R2
    AST_DIS_TRIPS: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && fb_mv < DIS_C) |=> (fb_disabled && !gate_permit)); // R3
    AST_GATE_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        gate_permit |-> run_en); // R4
    AST_RDY_COLLAPSE_LOW: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && sup_mv >= FLOAT_C && sup_mv < COLLAPSE_C) |=> rdy_pull_low); // R8
    AST_RDY_FLOATS: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && sup_mv < FLOAT_C) |=> !rdy_pull_low); // R9
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> ($stable(run_en) && $stable(ovp_trip) &&
                      $stable(fb_disabled) && $stable(rdy_pull_low))); // R10
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!run_en && !ovp_trip && !fb_disabled && !rdy_pull_low)); // R11
endmodule

bind supply_supervisor supply_supervisor_chk #(
    .SUP_W(SUP_W), .FB_W(FB_W), .START_MV(START_MV), .STOP_MV(STOP_MV),
    .OVP_ON_MV(OVP_ON_MV), .DIS_ON_MV(DIS_ON_MV),
    .COLLAPSE_MV(COLLAPSE_MV), .FLOAT_MV(FLOAT_MV)
) u_chk (.*);

// File: tb/supply_supervisor_test.sv
`timescale 1ns/1ps
module supply_supervisor_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_vld = 1'b0;
    logic [14:0] sup_mv = '0;
    logic [11:0] fb_mv = '0;
    logic        run_en, ovp_trip, fb_disabled, gate_permit, rdy_pull_low;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model
    bit    m_run, m_ovp, m_dis;
    int    m_st;          // 0 float, 1 hold low, 2 armed low, 3 armed high
    string m_tag;

    always #2.5 clk = ~clk;

    supply_supervisor uut (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .sup_mv(sup_mv), .fb_mv(fb_mv),
        .run_en(run_en), .ovp_trip(ovp_trip), .fb_disabled(fb_disabled),
        .gate_permit(gate_permit), .rdy_pull_low(rdy_pull_low)
    );

    function automatic bit exp_pull(input int st);
        return (st == 1) || (st == 2);
    endfunction

    task automatic model_step(input bit v, input int s, input int f);
        if (!v) begin
            m_tag = "R10";
            return;
        end
        if (s > 12000) m_run = 1'b1; else if (s < 8500) m_run = 1'b0;
        if (f > 2675) m_ovp = 1'b1; else if (f < 2500) m_ovp = 1'b0;
        if (f < 350) m_dis = 1'b1; else if (f > 450) m_dis = 1'b0;
        if (s < 2000) begin
            m_st = 0; m_tag = "R9";
        end else if (s < 5000) begin
            m_st = 1; m_tag = "R8";
        end else if (m_st <= 1) begin
            m_tag = "R6";
            if (s > 12000) m_st = (f > 2240) ? 3 : 2;
            else m_st = 1;
        end else begin
            if (m_st == 3 && f < 2051) m_st = 2;
            else if (m_st == 2 && f > 2240) m_st = 3;
            m_tag = (s < 8500) ? "R7" : "R5";
        end
    endtask

    task automatic chk(input string req, input bit act, input bit exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        chk((tag == "R10") ? "R10" : "R1", run_en, m_run, "run_en");
        chk((tag == "R10") ? "R10" : "R2", ovp_trip, m_ovp, "ovp_trip");
        chk((tag == "R10") ? "R10" : "R3", fb_disabled, m_dis, "fb_disabled");
        chk("R4", gate_permit, m_run && !m_ovp && !m_dis, "gate_permit");
        chk(tag, rdy_pull_low, exp_pull(m_st), "rdy_pull_low");
    endtask

    // called at a falling edge: drive, let one rising edge pass, check
    task automatic step(input bit v, input int s, input int f);
        smp_vld = v;
        sup_mv  = 15'(s);
        fb_mv   = 12'(f);
        model_step(v, s, f);
        @(negedge clk);
        check_all(m_tag);
    endtask

    function automatic int pick_sup(input int r);
        case (r % 12)
            0: return 1999;
            1: return 2000;
            2: return 4999;
            3: return 5000;
            4: return 8499;
            5: return 8500;
            6: return 12000;
            7: return 12001;
            8: return 500 + int'($urandom % 1500);
            default: return 5000 + int'($urandom % 11000);
        endcase
    endfunction

    function automatic int pick_fb(input int r);
        case (r % 14)
            0: return 349;
            1: return 350;
            2: return 450;
            3: return 451;
            4: return 2050;
            5: return 2051;
            6: return 2240;
            7: return 2241;
            8: return 2499;
            9: return 2500;
            10: return 2675;
            11: return 2676;
            default: return int'($urandom % 3200);
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7741));
        m_run = 0; m_ovp = 0; m_dis = 0; m_st = 0; m_tag = "R11";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_all("R11");                    // R11 reset state

        // R6: feedback already high, supply rising, no arming before start
        step(1, 3000, 2600);                 // R8 band: pulled low
        step(1, 9000, 2600);                 // R6 unarmed, still low
        step(1, 12000, 2600);                // equal to start: no arm, R1 hold
        step(1, 12001, 2600);                // arm, released high
        // R7: supply sags below stop, ready held
        step(1, 7000, 2600);
        step(1, 7000, 2100);                 // R5 hysteresis hold
        step(1, 7000, 2050);                 // R5 low
        step(1, 7000, 2241);                 // R5 high
        // R10: no strobe, no effect
        step(0, 1000, 100);
        step(0, 1000, 100);
        // R8 collapse, then R6 re-arm needed
        step(1, 4999, 2600);
        step(1, 9000, 2600);
        // R9 float
        step(1, 1999, 2600);
        // R2 over-voltage
        step(1, 13000, 2676);
        step(1, 13000, 2500);
        step(1, 13000, 2499);
        // R3 disable
        step(1, 13000, 349);
        step(1, 13000, 450);
        step(1, 13000, 451);

        // constrained random mix
        for (int i = 0; i < 6000; i++) begin
            step(($urandom % 4) != 0, pick_sup(int'($urandom % 1000)),
                 pick_fb(int'($urandom % 1000)));
            if (i == 3000) begin
                rst = 1'b1;
                @(negedge clk);
                rst = 1'b0;
                m_run = 0; m_ovp = 0; m_dis = 0; m_st = 0;
                check_all("R11");
            end
        end
        finish_run();
    end
endmodule